// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a page table with two levels held in ordinary memory. A root register holds the physical base of the top-level table; software loads it when it switches to another process. For each request the walker reads one entry from the top-level table, which gives the base of a second-level table. It then reads one entry from that table, which gives the page frame. The result is the frame address plus the byte offset, a page fault, or a protection fault.

The CPU side is a simple valid/ready request port with a one-cycle response pulse. The memory side is a read port with at most one read outstanding: the walker holds a read request until it is accepted, then waits for a single 64-bit entry to come back. When a translation succeeds the walker tells its caller to mark the entry as referenced, and for writes also as modified. It does not write the entry back itself.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is split into a first-level index in bits [31:22], a second-level index in bits [21:12] and a byte offset in bits [11:0]. For example, 0x00403004 selects first index 1, second index 3 and offset 4.
- R2: The first read goes to root + first_index*8, using the root value held when the request was accepted. The second read goes to {entry1[31:12], 12'h000} + second_index*8.
- R3: Entry layout: bit 0 present, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 referenced, bit 5 modified, bits [31:12] frame address. Bits [11:4] and [63:32] have no effect on the outcome.
- R4: If the first-level entry has present = 0, the response is a page fault (status 1) and no second read is issued.
- R5: If the second-level entry has present = 0, the response is a page fault (status 1), whatever its permission bits are.
- R6: The access kind codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. If the kind is not allowed by the matching bit of a present second-level entry, the response is a protection fault (status 2). Kind 3 always gives a protection fault. Status 3 is never produced.
- R7: On success the status is 0 and the physical address is {entry2[31:12], 12'h000} + offset.
- R8: On success the set-referenced flag is 1, and the set-modified flag is 1 only for writes. On any fault both flags are 0.
- R9: After reset the walker is idle with req_ready = 1. It accepts a request only when idle, and each accepted request gives exactly one response that is valid for one cycle.
- R10: Loading the root register while a walk is in progress does not change that walk. The new value is used from the next accepted request on.
- R11: A memory read request keeps its address and stays asserted until mem_req_ready is seen.
- R12: No new memory read is issued while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_load | input | 1 | Writes root_value into the root register |
| root_value | input | 32 | Physical base address of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response pulse (one cycle) |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr | output | 32 | Physical address when the status is ok |
| rsp_set_ref | output | 1 | Caller should set the referenced bit |
| rsp_set_mod | output | 1 | Caller should set the modified bit |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
The bench builds the walker with its default parameters: two 10-bit indices, a 12-bit offset, 32-bit physical addresses and 64-bit entries. With these values the known vector 0x00403004 can be checked directly. They also reach the edges of both tables (index 0 and index 1023) and a frame at the top of the physical space, where frame plus offset equals 0xFFFFFFFF. The memory model stalls read acceptance and varies the read latency, so the bench sees the hold and single-outstanding behaviour under backpressure. It also fills every field the walker should ignore with junk values.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry flag positions inside the low word of an entry
  localparam int PTE_PRESENT = 0;
  localparam int PTE_READ    = 1;
  localparam int PTE_WRITE   = 2;
  localparam int PTE_EXEC    = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PGF   = 2'd1,
    ST_PROT  = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_ISSUE,
    S_L1_WAIT,
    S_L2_ISSUE,
    S_L2_WAIT,
    S_DONE
  } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of one table entry from a table base and an index.
module ptw_entry_addr #(
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int ENT_W = 64
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int ENT_SHIFT = $clog2(ENT_W / 8);

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    logic [PA_W-1:0] scaled;
    scaled = PA_W'(i) << ENT_SHIFT;
    return b + scaled;
  endfunction

  assign entry_addr = slot_addr(table_base, index);
endmodule

// File: rtl/ptw_perm.sv
// Decides whether the final entry allows the requested kind of access.
module ptw_perm
  import ptw_pkg::*;
(
  input  logic    allow_rd,
  input  logic    allow_wr,
  input  logic    allow_ex,
  input  access_e kind,
  output logic    permitted
);
  always_comb begin
    unique case (kind)
      ACC_READ:  permitted = allow_rd;
      ACC_WRITE: permitted = allow_wr;
      ACC_EXEC:  permitted = allow_ex;
      default:   permitted = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int PA_W     = 32,
  parameter int ENT_W    = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             root_load,
  input  logic [PA_W-1:0]                  root_value,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] req_vaddr,
  input  logic [1:0]                       req_kind,
  output logic                             rsp_valid,
  output logic [1:0]                       rsp_status,
  output logic [PA_W-1:0]                  rsp_paddr,
  output logic                             rsp_set_ref,
  output logic                             rsp_set_mod,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic [PA_W-1:0]                  mem_req_addr,
  input  logic                             mem_rsp_valid,
  input  logic [ENT_W-1:0]                 mem_rsp_data
);
  localparam int VA_W    = L1_BITS + L2_BITS + OFF_BITS;
  localparam int L1_LSB  = L2_BITS + OFF_BITS;
  localparam int FRAME_W = PA_W - OFF_BITS;

  // frame field of an entry, re-aligned as a full physical address
  function automatic logic [PA_W-1:0] frame_base(input logic [ENT_W-1:0] e);
    return {e[PA_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [PA_W-1:0] fb,
                                                 input logic [OFF_BITS-1:0] off);
    return fb + PA_W'(off);
  endfunction

  walk_state_e        state_q;
  logic [PA_W-1:0]    root_q;
  logic [PA_W-1:0]    walk_root_q;
  logic [PA_W-1:0]    l2_base_q;
  logic [VA_W-1:0]    vaddr_q;
  access_e            kind_q;
  walk_status_e       status_q;
  logic [PA_W-1:0]    paddr_q;
  logic               set_ref_q;
  logic               set_mod_q;

  // named internal events
  logic walk_start;
  logic l1_arrive;
  logic l2_arrive;
  logic entry_present;
  logic perm_ok;
  logic [PA_W-1:0] l1_slot;
  logic [PA_W-1:0] l2_slot;

  assign walk_start    = req_valid && req_ready;
  assign l1_arrive     = (state_q == S_L1_WAIT) && mem_rsp_valid;
  assign l2_arrive     = (state_q == S_L2_WAIT) && mem_rsp_valid;
  assign entry_present = mem_rsp_data[PTE_PRESENT];

  ptw_entry_addr #(.PA_W(PA_W), .IDX_W(L1_BITS), .ENT_W(ENT_W)) u_l1_addr (
    .table_base (walk_root_q),
    .index      (vaddr_q[VA_W-1:L1_LSB]),
    .entry_addr (l1_slot)
  );

  ptw_entry_addr #(.PA_W(PA_W), .IDX_W(L2_BITS), .ENT_W(ENT_W)) u_l2_addr (
    .table_base (l2_base_q),
    .index      (vaddr_q[L1_LSB-1:OFF_BITS]),
    .entry_addr (l2_slot)
  );

  ptw_perm u_perm (
    .allow_rd  (mem_rsp_data[PTE_READ]),
    .allow_wr  (mem_rsp_data[PTE_WRITE]),
    .allow_ex  (mem_rsp_data[PTE_EXEC]),
    .kind      (kind_q),
    .permitted (perm_ok)
  );

  logic unused_entry_bits;
  assign unused_entry_bits = ^{mem_rsp_data[ENT_W-1:PA_W],
                               mem_rsp_data[OFF_BITS-1:PTE_EXEC+1]};

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_L1_ISSUE) || (state_q == S_L2_ISSUE);
  assign mem_req_addr  = (state_q == S_L2_ISSUE) ? l2_slot : l1_slot;
  assign rsp_valid     = (state_q == S_DONE);
  assign rsp_status    = status_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_set_ref   = set_ref_q;
  assign rsp_set_mod   = set_mod_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      root_q      <= '0;
      walk_root_q <= '0;
      l2_base_q   <= '0;
      vaddr_q     <= '0;
      kind_q      <= ACC_READ;
      status_q    <= ST_OK;
      paddr_q     <= '0;
      set_ref_q   <= 1'b0;
      set_mod_q   <= 1'b0;
    end else begin
      if (root_load) root_q <= root_value;
      unique case (state_q)
        S_IDLE: if (walk_start) begin
          vaddr_q     <= req_vaddr;
          kind_q      <= access_e'(req_kind);
          walk_root_q <= root_q;
          state_q     <= S_L1_ISSUE;
        end
        S_L1_ISSUE: if (mem_req_ready) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (l1_arrive) begin
          if (!entry_present) begin
            status_q  <= ST_PGF;
            paddr_q   <= '0;
            set_ref_q <= 1'b0;
            set_mod_q <= 1'b0;
            state_q   <= S_DONE;
          end else begin
            l2_base_q <= frame_base(mem_rsp_data);
            state_q   <= S_L2_ISSUE;
          end
        end
        S_L2_ISSUE: if (mem_req_ready) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (l2_arrive) begin
          state_q <= S_DONE;
          if (!entry_present || !perm_ok) begin
            status_q  <= entry_present ? ST_PROT : ST_PGF;
            paddr_q   <= '0;
            set_ref_q <= 1'b0;
            set_mod_q <= 1'b0;
          end else begin
            status_q  <= ST_OK;
            paddr_q   <= join_paddr(frame_base(mem_rsp_data), vaddr_q[OFF_BITS-1:0]);
            set_ref_q <= 1'b1;
            set_mod_q <= (kind_q == ACC_WRITE);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // FRAME_W documents the frame field width used by frame_base
  initial begin
    if (FRAME_W <= 0) $display("ptw_walker: physical width must exceed offset width");
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int PA_W     = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                req_valid,
  input logic                                req_ready,
  input logic [L1_BITS+L2_BITS+OFF_BITS-1:0] req_vaddr,
  input logic                                rsp_valid,
  input logic [1:0]                          rsp_status,
  input logic [PA_W-1:0]                     rsp_paddr,
  input logic                                rsp_set_ref,
  input logic                                rsp_set_mod,
  input logic                                mem_req_valid,
  input logic                                mem_req_ready,
  input logic [PA_W-1:0]                     mem_req_addr,
  input logic                                mem_rsp_valid
);
  logic                pend_q;
  logic [OFF_BITS-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      off_q  <= '0;
    end else begin
      if (req_valid && req_ready) off_q <= req_vaddr[OFF_BITS-1:0];
      if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid)             pend_q <= 1'b0;
    end
  end

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req_valid);

  p_fault_no_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (!rsp_set_ref && !rsp_set_mod));

  p_mod_implies_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_set_mod) |-> rsp_set_ref);

  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[OFF_BITS-1:0] == off_q));

  p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));
endmodule

bind ptw_walker ptw_walker_chk #(
  .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS), .PA_W(PA_W)
) u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_load = 1'b0;
  logic [31:0] root_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic        rsp_set_ref, rsp_set_mod;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  ptw_walker dut (.*);

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [1:0]  st;
    logic [31:0] pa;
    logic        rf;
    logic        md;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  logic [63:0] mem [logic [31:0]];
  logic [31:0] cur_root;

  function automatic logic [63:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // junk in every field that must not matter (R3)
  function automatic logic [63:0] mk_ent(input logic [31:0] frame, input logic [3:0] xwrp,
                                         input logic [1:0] refmod);
    return {32'hDEAD_BEEF, frame[31:12], 6'b101101, refmod, xwrp};
  endfunction

  // memory model: stalls and varying latency
  int        cyc = 0;
  logic      pend = 1'b0;
  int        lat = 0;
  logic [31:0] pend_addr;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      total++;
      if (addr_q.size() == 0) begin
        bad++;
        $display("FAIL R4/R12 unexpected read addr=%h expected=none", mem_req_addr);
      end else begin
        if (mem_req_addr !== addr_q[0]) begin
          bad++;
          $display("FAIL R2 read addr=%h expected=%h", mem_req_addr, addr_q[0]);
        end
        void'(addr_q.pop_front());
      end
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      lat       <= cyc % 3;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(pend_addr);
        pend          <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  // monitor: compare each response against the scoreboard
  int rsp_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 extra response st=%0d expected=none", rsp_status);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_status !== e.st || (e.st == 2'd0 && rsp_paddr !== e.pa) ||
            rsp_set_ref !== e.rf || rsp_set_mod !== e.md) begin
          bad++;
          $display("FAIL %s st=%0d pa=%h ref=%0b mod=%0b expected st=%0d pa=%h ref=%0b mod=%0b",
                   e.tag, rsp_status, rsp_paddr, rsp_set_ref, rsp_set_mod,
                   e.st, e.pa, e.rf, e.md);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // driver: predicts the walk from the requirements, then presents the request
  task automatic issue(input logic [31:0] va, input logic [1:0] kind, input string tag);
    exp_t e;
    logic [31:0] a1, a2;
    logic [63:0] e1, e2;
    bit allowed;
    a1 = cur_root + 32'(va[31:22]) * 8;
    addr_q.push_back(a1);
    e1 = rd(a1);
    e.tag = tag; e.pa = '0; e.rf = 1'b0; e.md = 1'b0;
    if (!e1[0]) e.st = 2'd1;
    else begin
      a2 = {e1[31:12], 12'h000} + 32'(va[21:12]) * 8;
      addr_q.push_back(a2);
      e2 = rd(a2);
      allowed = (kind == 2'd0 && e2[1]) || (kind == 2'd1 && e2[2]) || (kind == 2'd2 && e2[3]);
      if (!e2[0]) e.st = 2'd1;
      else if (!allowed) e.st = 2'd2;
      else begin
        e.st = 2'd0;
        e.pa = {e2[31:12], 12'h000} + 32'(va[11:0]);
        e.rf = 1'b1;
        e.md = (kind == 2'd1);
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready while busy", 32'(req_ready), 32'd0);
  endtask

  localparam logic [31:0] ROOT0 = 32'h0010_0000;
  localparam logic [31:0] ROOT1 = 32'h0050_0000;
  localparam logic [31:0] T1 = 32'h0020_0000;
  localparam logic [31:0] T3 = 32'h0030_0000;
  localparam logic [31:0] T4 = 32'h0040_0000;

  initial begin
    // level-1 tables
    mem[ROOT0 + 1*8]    = mk_ent(T1, 4'b0001, 2'b00);
    mem[ROOT0 + 2*8]    = mk_ent(T3, 4'b1110, 2'b11);   // absent
    mem[ROOT0 + 3*8]    = mk_ent(T3, 4'b0001, 2'b00);
    mem[ROOT0 + 1023*8] = mk_ent(T4, 4'b1111, 2'b00);
    mem[ROOT1 + 1*8]    = mk_ent(T3, 4'b0001, 2'b00);
    // level-2 tables
    mem[T1 + 3*8]    = mk_ent(32'h1234_5000, 4'b0111, 2'b00); // R W
    mem[T1 + 4*8]    = mk_ent(32'h00AB_C000, 4'b0011, 2'b00); // R only
    mem[T1 + 5*8]    = mk_ent(32'h5555_5000, 4'b1110, 2'b00); // absent
    mem[T1 + 6*8]    = mk_ent(32'h7777_7000, 4'b1001, 2'b00); // X only
    mem[T3 + 0*8]    = mk_ent(32'hFFFF_F000, 4'b1111, 2'b00);
    mem[T4 + 1023*8] = mk_ent(32'h0000_1000, 4'b1111, 2'b11);

    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R9 reset state", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R9 idle after reset", 32'(req_ready), 32'd1);

    root_load = 1'b1; root_value = ROOT0; @(negedge clk); root_load = 1'b0;
    cur_root = ROOT0;

    issue(32'h0040_3004, 2'd0, "R1/R7 vector 0x00403004 read");
    issue(32'h0040_3FFC, 2'd1, "R8 write sets modified");
    issue(32'h0040_4010, 2'd1, "R6 write to read-only");
    issue(32'h0040_4010, 2'd0, "R7 read of read-only");
    issue(32'h0040_5000, 2'd0, "R5 second level absent");
    issue(32'h0080_0123, 2'd0, "R4 first level absent");
    issue(32'h0040_6ABC, 2'd2, "R6 execute allowed");
    issue(32'h0040_6ABC, 2'd0, "R6 read of execute-only");
    issue(32'h0040_3004, 2'd3, "R6 reserved kind");
    issue(32'h00C0_0FFF, 2'd1, "R7 top frame boundary");
    issue(32'hFFFF_F008, 2'd2, "R3 last slots, ref/mod bits ignored");
    issue(32'h0123_4567, 2'd0, "R4 unpopulated first level");

    // R10: root load during a walk leaves that walk alone
    issue(32'h0040_3010, 2'd0, "R10 walk uses old root");
    root_load = 1'b1; root_value = ROOT1; @(negedge clk); root_load = 1'b0;
    cur_root = ROOT1;
    issue(32'h0040_0020, 2'd1, "R10 next walk uses new root");
    root_load = 1'b1; root_value = ROOT0; @(negedge clk); root_load = 1'b0;
    cur_root = ROOT0;

    for (int i = 0; i < 32; i++) begin
      logic [9:0] hi;
      case (i % 4)
        0: hi = 10'd1;
        1: hi = 10'd2;
        2: hi = 10'd3;
        default: hi = 10'd1023;
      endcase
      issue({hi, 10'(i % 8 + ((i % 4 == 3) ? 1016 : 0)), 12'(i * 37)}, 2'(i % 4),
            "R2/R6/R7 sweep");
    end

    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9 responses outstanding", 32'(exp_q.size()), 32'd0);
    check(addr_q.size() == 0, "R2 reads missing", 32'(addr_q.size()), 32'd0);
    check(rsp_cnt == 46, "R9 one response per request", 32'(rsp_cnt), 32'd46);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule